// File: doc/BRIEF.md
# Receive Byte Queue with Pre-Dequeue Status

This block buffers bytes that a modem receiver delivers, 32 entries deep, until a host collects them. Each host read strobe yields one registered read word. The word pairs the oldest stored byte with a status snapshot: full, empty and a coarse fill level. The snapshot shows the queue as it stood before that read removed its byte. Because of this, a host that sees the empty bit set knows that the byte beside it carries no new data.

Occupancy is held in a 5-bit counter, so an occupancy of 32 wraps to zero. A separate full bit keeps the full and empty states apart. The reported level is the counter with its least significant bit dropped, which means occupancies 0, 1 and 32 all report level 0. The host tells these three cases apart using the full and empty bits.

A high-water comparator drives a level flag that can feed an interrupt. The flag is set when the 5-bit counter is strictly greater than the 4-bit threshold with a 1 appended as its least significant bit. The register file outside this block supplies the threshold, with a default of 4'b1111. At that setting the flag can never rise, because the wrapped counter never exceeds 31.

Top module: `rxq_snap_fifo`

## Requirements
- R1: A synchronous active-high reset empties the queue. In the cycle after reset, empty_o is 1, full_o and lvl_flag_o are 0, and rd_word_o is all zeros.
- R2: full_o is 1 exactly when 32 bytes are stored. empty_o is 1 exactly when none are stored. The two are never 1 together.
- R3: Bytes leave in arrival order. A read strobe sampled at a clock edge loads rd_word_o at that same edge. rd_word_o then holds its value until the next strobe. The byte sits in bits [7:0].
- R4: The status fields of rd_word_o show the queue before the read's dequeue. Bit 13 is full, bit 12 is empty, and bits [11:8] are the occupancy modulo 32 shifted right by one. Occupancies 0, 1 and 32 therefore all read level 0.
- R5: lvl_flag_o is 1 exactly when (occupancy modulo 32) > {thr_i, 1'b1}.
- R6: With thr_i = 4'b1111, lvl_flag_o stays 0 at every occupancy, including full.
- R7: A push offered while the queue is full is discarded, even when a read happens in the same cycle. The stored bytes and the occupancy are left unchanged by the push.
- R8: A read on an empty queue changes nothing in the queue. It returns a word with bit 12 set and with bits [7:0] equal to the byte of the previous read word.
- R9: A push and a read in the same cycle on a queue that is neither empty nor full keep the occupancy constant.
- R10: A push and a read in the same cycle on an empty queue store the pushed byte, and the read reports empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| push_i | input | 1 | Receive byte valid |
| push_data_i | input | 8 | Receive byte |
| rd_i | input | 1 | Host read strobe |
| thr_i | input | 4 | High-water threshold, upper bits |
| rd_word_o | output | 14 | {full, empty, level[3:0], data[7:0]} from the last read |
| full_o | output | 1 | Queue holds 32 bytes |
| empty_o | output | 1 | Queue holds no bytes |
| lvl_flag_o | output | 1 | High-water flag |

## Verification
On every cycle, the assertions check several properties: full and empty are never set together, a blocked push leaves a full queue and its write pointer unchanged, an empty read keeps the queue empty, and a balanced push and read holds the occupancy. They also check that the read word holds between strobes and that the default threshold keeps the flag low. Three behaviours are shown only by the bench's scenarios, which compare every cycle against a queue model. These are the byte order across overflow, the aliasing of level 0 at occupancies 0, 1 and 32, and the stale byte returned by an empty read.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int RXQ_DEPTH  = 32;
    localparam int RXQ_DATA_W = 8;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DEPTH  = rxq_pkg::RXQ_DEPTH,
    parameter int DATA_W = rxq_pkg::RXQ_DATA_W,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk_i,
    input  logic              we_i,
    input  logic [AW-1:0]     waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [AW-1:0]     raddr_i,
    output logic [DATA_W-1:0] rdata_o
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk_i) begin
        if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
    parameter int DEPTH = rxq_pkg::RXQ_DEPTH,
    localparam int AW   = $clog2(DEPTH),
    localparam int TW   = AW - 1
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          push_i,
    input  logic          rd_i,
    input  logic [TW-1:0] thr_i,
    output logic          wr_en_o,
    output logic [AW-1:0] wr_ptr_o,
    output logic [AW-1:0] rd_ptr_o,
    output logic [AW-1:0] cnt_o,
    output logic          full_o,
    output logic          empty_o,
    output logic          lvl_flag_o
);
    typedef struct packed {
        logic [AW-1:0] wr_ptr;
        logic [AW-1:0] rd_ptr;
        logic [AW-1:0] cnt;
        logic          full;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic  do_push, do_pop, empty_w;

    assign empty_w = (st_q.cnt == '0) && !st_q.full;
    assign do_push = push_i && !st_q.full;
    assign do_pop  = rd_i && !empty_w;

    always_comb begin
        st_d = st_q;
        if (do_push) begin
            st_d.wr_ptr = st_q.wr_ptr + 1'b1;
        end
        if (do_pop) begin
            st_d.rd_ptr = st_q.rd_ptr + 1'b1;
        end
        st_d.cnt = st_q.cnt + AW'(do_push) - AW'(do_pop);
        if (do_pop) begin
            st_d.full = 1'b0;
        end else if (do_push && (st_q.cnt == AW'(DEPTH - 1))) begin
            st_d.full = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_en_o    = do_push;
    assign wr_ptr_o   = st_q.wr_ptr;
    assign rd_ptr_o   = st_q.rd_ptr;
    assign cnt_o      = st_q.cnt;
    assign full_o     = st_q.full;
    assign empty_o    = empty_w;
    assign lvl_flag_o = st_q.cnt > {thr_i, 1'b1};

    AST_RESET_EMPTY: assert property (@(posedge clk_i)
        rst_i |=> empty_o && !full_o && !lvl_flag_o); // R1
    AST_FULL_EMPTY_EXCL: assert property (@(posedge clk_i) disable iff (rst_i)
        !(full_o && empty_o)); // R2
    AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (rst_i)
        full_o && push_i && !rd_i |=> full_o && $stable(wr_ptr_o)); // R7
    AST_EMPTY_READ: assert property (@(posedge clk_i) disable iff (rst_i)
        empty_o && rd_i && !push_i |=> empty_o && $stable(rd_ptr_o)); // R8
    AST_BALANCED: assert property (@(posedge clk_i) disable iff (rst_i)
        push_i && rd_i && !full_o && !empty_o |=> $stable(cnt_o) && !full_o); // R9
    AST_DEFAULT_THR_OFF: assert property (@(posedge clk_i) disable iff (rst_i)
        (&thr_i) |-> !lvl_flag_o); // R6
endmodule

// File: rtl/rxq_snap_fifo.sv
module rxq_snap_fifo #(
    parameter int DEPTH  = rxq_pkg::RXQ_DEPTH,
    parameter int DATA_W = rxq_pkg::RXQ_DATA_W,
    localparam int AW    = $clog2(DEPTH),
    localparam int TW    = AW - 1,
    localparam int WW    = DATA_W + TW + 2
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              push_i,
    input  logic [DATA_W-1:0] push_data_i,
    input  logic              rd_i,
    input  logic [TW-1:0]     thr_i,
    output logic [WW-1:0]     rd_word_o,
    output logic              full_o,
    output logic              empty_o,
    output logic              lvl_flag_o
);
    typedef struct packed {
        logic              full;
        logic              empty;
        logic [TW-1:0]     level;
        logic [DATA_W-1:0] data;
    } word_t;

    word_t             word_d, word_q;
    logic              wr_en;
    logic [AW-1:0]     wr_ptr, rd_ptr, cnt;
    logic [DATA_W-1:0] head_byte;
    logic              full_w, empty_w;

    rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .push_i     (push_i),
        .rd_i       (rd_i),
        .thr_i      (thr_i),
        .wr_en_o    (wr_en),
        .wr_ptr_o   (wr_ptr),
        .rd_ptr_o   (rd_ptr),
        .cnt_o      (cnt),
        .full_o     (full_w),
        .empty_o    (empty_w),
        .lvl_flag_o (lvl_flag_o)
    );

    rxq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk_i   (clk_i),
        .we_i    (wr_en),
        .waddr_i (wr_ptr),
        .wdata_i (push_data_i),
        .raddr_i (rd_ptr),
        .rdata_o (head_byte)
    );

    always_comb begin
        word_d = word_q;
        if (rd_i) begin
            word_d.full  = full_w;
            word_d.empty = empty_w;
            word_d.level = cnt[AW-1:1];
            word_d.data  = empty_w ? word_q.data : head_byte;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            word_q <= '0;
        end else begin
            word_q <= word_d;
        end
    end

    assign rd_word_o = word_q;
    assign full_o    = full_w;
    assign empty_o   = empty_w;

    AST_WORD_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        !rd_i |=> $stable(rd_word_o)); // R3
    AST_SNAP_EMPTY: assert property (@(posedge clk_i) disable iff (rst_i)
        rd_i && empty_o |=> rd_word_o[WW-2]); // R8
endmodule

// File: tb/rxq_snap_fifo_bench.sv
module rxq_snap_fifo_bench;
    logic        clk = 1'b0;
    logic        rst, push, rd;
    logic [7:0]  pdata;
    logic [3:0]  thr;
    logic [13:0] rd_word;
    logic        full, empty, lvl;
    int          checks = 0;
    int          failures = 0;
    bit          done = 1'b0;

    byte unsigned q[$];
    logic [13:0]  exp_word = '0;
    byte unsigned seed = 8'h10;

    always #2 clk = ~clk;

    rxq_snap_fifo u_rxq_snap_fifo (
        .clk_i(clk), .rst_i(rst), .push_i(push), .push_data_i(pdata),
        .rd_i(rd), .thr_i(thr), .rd_word_o(rd_word), .full_o(full),
        .empty_o(empty), .lvl_flag_o(lvl)
    );

    task automatic chk(string tag, logic [13:0] act, logic [13:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic compare_all(string tag);
        int occ = q.size();
        chk({tag, " R2 full"},  14'(full),  14'(occ == 32));
        chk({tag, " R2 empty"}, 14'(empty), 14'(occ == 0));
        chk({tag, " R5 lvl"},   14'(lvl),   14'((occ % 32) > (int'(thr) * 2 + 1)));
        chk({tag, " R3/R4 word"}, rd_word, exp_word);
    endtask

    task automatic step(bit p, bit r, string tag);
        int pre;
        @(negedge clk);
        push = p; rd = r; pdata = seed;
        @(posedge clk);
        pre = q.size();
        if (r) begin
            exp_word[13]   = (pre == 32);
            exp_word[12]   = (pre == 0);
            exp_word[11:8] = 4'((pre % 32) >> 1);
            if (pre > 0) exp_word[7:0] = q[0];
        end
        if (r && pre > 0) void'(q.pop_front());
        if (p && pre < 32) q.push_back(seed);
        if (p) seed = seed + 8'd7;
        #1;
        compare_all(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; push = 1'b0; rd = 1'b0; pdata = '0; thr = 4'hF;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        compare_all("R1 reset");
        // R8 read while empty after reset
        step(0, 1, "R8 empty read");
        // fill a few, check level and order
        thr = 4'h0;
        for (int i = 0; i < 5; i++) step(1, 0, "R5 fill thr0");
        thr = 4'h2;
        for (int i = 0; i < 3; i++) step(1, 0, "R5 fill thr2");
        for (int i = 0; i < 3; i++) step(0, 1, "R3 R4 read");
        step(1, 1, "R9 balanced");
        step(1, 1, "R9 balanced");
        // fill to full with default threshold
        thr = 4'hF;
        while (q.size() < 32) step(1, 0, "R6 fill default thr");
        for (int i = 0; i < 3; i++) step(1, 0, "R7 overflow push");
        step(1, 1, "R7 push with read on full");
        step(1, 0, "R2 refill");
        step(0, 1, "R4 read at 32");
        // drain completely
        while (q.size() > 0) step(0, 1, "R3 drain");
        step(0, 1, "R8 stale read");
        step(0, 1, "R8 stale read again");
        step(1, 1, "R10 push and read on empty");
        step(0, 1, "R4 read at 1");
        step(0, 1, "R8 empty after");
        // mid-stream reset
        for (int i = 0; i < 4; i++) step(1, 0, "R2 prefill");
        step(0, 1, "R3 read");
        @(negedge clk); rst = 1'b1; push = 1'b0; rd = 1'b0;
        @(negedge clk); rst = 1'b0;
        q.delete(); exp_word = '0;
        compare_all("R1 reset midstream");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule